// File: doc/BRIEF.md
# USB Endpoint Handshake Status Controller

This block keeps the status and mode configuration of a single USB device endpoint and chooses the reply to every token that the protocol engine routes to it. The engine presents the decoded token PID. One clock later the block answers with a handshake choice: accept the transaction, NAK, STALL, or stay silent. When the data phase of an accepted transaction ends, the engine pulses a completion strobe with a success flag. On success the block raises a correct-transfer flag. For ordinary endpoints it moves the status of the direction used to NAK, so firmware must rearm it. For isochronous endpoints it instead flips the data toggle of the active direction.

In isochronous mode no handshake is sent, and both descriptor pairs act as one ping-pong buffer. The direction's toggle bit selects the pair that the interface uses: select 0 means the interface uses the transmit address/count pair, and select 1 means it uses the receive pair. Firmware owns the other pair. Software updates every field with one write strobe. Token, completion and write inputs are single-cycle strobes with no back-pressure, because the endpoint always answers in a fixed time. For that reason the block has no valid/ready pairs.

Top module: `ep_hs_ctrl`

## Requirements
- R1: After reset, all status fields, mode bits, toggles, the correct-transfer flag, the captured PID, the buffer select and hs_valid are 0.
- R2: An IN token (PID 4'b1001) on a non-isochronous endpoint gives hs_valid one cycle later. hs_code is taken from the transmit status: 00 (disabled) gives 00 (no reply), 01 (stall) gives 11 (STALL), 10 (nak) gives 10 (NAK), and 11 (valid) gives 01 (accept).
- R3: An OUT token (PID 4'b0001) on a non-isochronous endpoint gives the same mapping, taken from the receive status.
- R4: A SETUP token (PID 4'b1101) on a control endpoint is accepted when the receive status is valid or stall, and gets no reply when it is nak or disabled. On a non-control endpoint SETUP gets no reply. A PID whose low two bits are not 01, or whose top two bits are 01, is ignored: no hs_valid and no capture.
- R5: A successful completion of an accepted transaction on a non-isochronous endpoint sets the status to nak. An IN sets the transmit status, an OUT sets the receive status, and a SETUP sets both. A failed completion changes no status and no flag.
- R6: The correct-transfer flag is set by a successful completion. Only a software write carrying 0 in the flag position clears it, and a write carrying 1 leaves it unchanged. A completion in the same cycle as a clearing write wins.
- R7: pid_rx takes the top two PID bits of each recognised token (00 OUT, 10 IN, 11 SETUP), but only while the correct-transfer flag is 0. While the flag is 1, pid_rx is frozen.
- R8: In isochronous mode, hardware never changes either status field. A token is accepted only when its direction's status is valid; every other encoding gives no reply.
- R9: In isochronous mode, each successful IN completion inverts the transmit toggle, and each successful OUT completion inverts the receive toggle.
- R10: buf_sel is 0 on a non-isochronous endpoint. In isochronous mode it equals the transmit toggle when the transmit status is not disabled, and the receive toggle otherwise.
- R11: A software write that sets the isochronous bit with a transmit status other than disabled forces the receive status to disabled, so that only one direction is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | Token strobe |
| tok_pid | input | PID_W | Full token PID |
| xfer_done | input | 1 | Transaction completion strobe |
| xfer_ok | input | 1 | Completion was successful |
| sw_wr | input | 1 | Software write strobe for all fields |
| sw_stat_tx | input | 2 | Transmit status to write |
| sw_stat_rx | input | 2 | Receive status to write |
| sw_cep | input | 1 | Control endpoint bit to write |
| sw_iso | input | 1 | Isochronous bit to write |
| sw_tog_tx | input | 1 | Transmit toggle to write |
| sw_tog_rx | input | 1 | Receive toggle to write |
| sw_ctr | input | 1 | Flag write value (0 clears, 1 keeps) |
| hs_valid | output | 1 | Handshake decision valid |
| hs_code | output | 2 | 00 none, 01 accept, 10 NAK, 11 STALL |
| ctr_flag | output | 1 | Correct-transfer flag |
| pid_rx | output | 2 | Captured top PID bits |
| stat_tx | output | 2 | Transmit status |
| stat_rx | output | 2 | Receive status |
| cep | output | 1 | Control endpoint bit |
| iso | output | 1 | Isochronous bit |
| tog_tx | output | 1 | Transmit data toggle |
| tog_rx | output | 1 | Receive data toggle |
| buf_sel | output | 1 | Descriptor pair used by the interface |

## Verification
The bench builds the block with its defaults: PID_W of 4 and ISO_ENABLE set. The full 4-bit PID lets start-of-frame and malformed codes be driven next to the three token kinds. With the isochronous variant present, toggle-driven buffer alternation and the one-direction rule can be reached in both directions. A behavioural model is compared on every clock, and directed checks probe each status encoding against each token kind.

// File: rtl/ep_hs_pkg.sv
package ep_hs_pkg;
  localparam int STAT_W = 2;
  localparam int HS_W   = 2;

  typedef enum logic [STAT_W-1:0] {
    ST_DIS = 2'b00, ST_STALL = 2'b01, ST_NAK = 2'b10, ST_VALID = 2'b11
  } ep_stat_e;

  typedef enum logic [HS_W-1:0] {
    HS_NONE = 2'b00, HS_ACCEPT = 2'b01, HS_NAK = 2'b10, HS_STALL = 2'b11
  } hs_code_e;

  // top two PID bits; value 01 is a non-token kind
  typedef enum logic [1:0] {
    TK_OUT = 2'b00, TK_OTHER = 2'b01, TK_IN = 2'b10, TK_SETUP = 2'b11
  } tok_kind_e;

  typedef struct packed {
    ep_stat_e tx;
    ep_stat_e rx;
    logic     cep;
    logic     iso;
    logic     tog_tx;
    logic     tog_rx;
  } ep_cfg_t;
endpackage

// File: rtl/ep_hs_decide.sv
module ep_hs_decide
  import ep_hs_pkg::*;
(
  input  ep_cfg_t   cfg,
  input  tok_kind_e kind,
  output hs_code_e  code
);
  ep_stat_e dir_stat;

  always_comb begin
    dir_stat = (kind == TK_IN) ? cfg.tx : cfg.rx;
    code     = HS_NONE;
    if (kind == TK_SETUP) begin
      if (cfg.cep && (cfg.rx == ST_VALID || cfg.rx == ST_STALL))
        code = HS_ACCEPT;
    end else if (cfg.iso) begin
      if (dir_stat == ST_VALID) code = HS_ACCEPT;
    end else begin
      case (dir_stat)
        ST_STALL: code = HS_STALL;
        ST_NAK:   code = HS_NAK;
        ST_VALID: code = HS_ACCEPT;
        default:  code = HS_NONE;
      endcase
    end
  end
endmodule

// File: rtl/ep_hs_track.sv
module ep_hs_track
  import ep_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tok_hit,
  input  tok_kind_e kind,
  input  hs_code_e  hs_now,
  input  logic      xfer_done,
  input  logic      xfer_ok,
  input  logic      ctr_q,
  output logic      hs_valid_q,
  output hs_code_e  hs_code_q,
  output tok_kind_e pid_q,
  output logic      pend_q,
  output tok_kind_e pkind_q,
  output logic      done_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_valid_q <= 1'b0;
      hs_code_q  <= HS_NONE;
      pid_q      <= TK_OUT;
      pend_q     <= 1'b0;
      pkind_q    <= TK_OUT;
    end else begin
      hs_valid_q <= tok_hit;
      hs_code_q  <= tok_hit ? hs_now : HS_NONE;
      if (tok_hit && !ctr_q) pid_q <= kind;
      if (tok_hit) begin
        pend_q  <= (hs_now == HS_ACCEPT);
        pkind_q <= kind;
      end else if (xfer_done) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign done_ok = xfer_done && xfer_ok && pend_q;
endmodule

// File: rtl/ep_hs_regs.sv
module ep_hs_regs
  import ep_hs_pkg::*;
#(
  parameter bit ISO_ENABLE = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      done_ok,
  input  tok_kind_e done_kind,
  input  logic      sw_wr,
  input  ep_cfg_t   sw_cfg,
  input  logic      sw_ctr,
  output ep_cfg_t   cfg_q,
  output logic      ctr_q
);
  ep_cfg_t cfg_n;
  logic    ctr_n;

  always_comb begin
    cfg_n = cfg_q;
    ctr_n = ctr_q;
    if (done_ok) begin
      ctr_n = 1'b1;
      if (cfg_q.iso) begin
        if (done_kind == TK_IN)  cfg_n.tog_tx = ~cfg_q.tog_tx;
        if (done_kind == TK_OUT) cfg_n.tog_rx = ~cfg_q.tog_rx;
      end else begin
        case (done_kind)
          TK_IN:    cfg_n.tx = ST_NAK;
          TK_OUT:   cfg_n.rx = ST_NAK;
          TK_SETUP: begin
            cfg_n.tx = ST_NAK;
            cfg_n.rx = ST_NAK;
          end
          default: ;
        endcase
      end
    end
    if (sw_wr) begin
      cfg_n = sw_cfg;
      if (!ISO_ENABLE) cfg_n.iso = 1'b0;
      if (cfg_n.iso && cfg_n.tx != ST_DIS) cfg_n.rx = ST_DIS;
      if (!sw_ctr && !done_ok) ctr_n = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '0;
      ctr_q <= 1'b0;
    end else begin
      cfg_q <= cfg_n;
      ctr_q <= ctr_n;
    end
  end
endmodule

// File: rtl/ep_hs_bufsel.sv
module ep_hs_bufsel
  import ep_hs_pkg::*;
#(
  parameter bit ISO_ENABLE = 1'b1
) (
  input  ep_cfg_t cfg,
  output logic    sel
);
  generate
    if (ISO_ENABLE) begin : g_iso
      assign sel = cfg.iso && ((cfg.tx != ST_DIS) ? cfg.tog_tx : cfg.tog_rx);
    end else begin : g_plain
      assign sel = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ep_hs_ctrl.sv
module ep_hs_ctrl
  import ep_hs_pkg::*;
#(
  parameter int PID_W      = 4,
  parameter bit ISO_ENABLE = 1'b1,
  parameter logic [PID_W-3:0] TOKEN_TAG = 'b01
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_valid,
  input  logic [PID_W-1:0] tok_pid,
  input  logic             xfer_done,
  input  logic             xfer_ok,
  input  logic             sw_wr,
  input  logic [1:0]       sw_stat_tx,
  input  logic [1:0]       sw_stat_rx,
  input  logic             sw_cep,
  input  logic             sw_iso,
  input  logic             sw_tog_tx,
  input  logic             sw_tog_rx,
  input  logic             sw_ctr,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             ctr_flag,
  output logic [1:0]       pid_rx,
  output logic [1:0]       stat_tx,
  output logic [1:0]       stat_rx,
  output logic             cep,
  output logic             iso,
  output logic             tog_tx,
  output logic             tog_rx,
  output logic             buf_sel
);
  localparam int KIND_W   = 2;
  localparam int KIND_LSB = PID_W - KIND_W;

  tok_kind_e kind;
  logic      tok_hit;
  hs_code_e  hs_now, hs_code_q;
  tok_kind_e pid_q, pkind_q;
  logic      pend_q, done_ok, ctr_q;
  ep_cfg_t   cfg_q, sw_cfg;

  assign kind    = tok_kind_e'(tok_pid[PID_W-1:KIND_LSB]);
  assign tok_hit = tok_valid && (tok_pid[KIND_LSB-1:0] == TOKEN_TAG) && (kind != TK_OTHER);

  assign sw_cfg = '{tx: ep_stat_e'(sw_stat_tx), rx: ep_stat_e'(sw_stat_rx), cep: sw_cep,
                    iso: sw_iso, tog_tx: sw_tog_tx, tog_rx: sw_tog_rx};

  ep_hs_decide u_decide (.cfg(cfg_q), .kind(kind), .code(hs_now));

  ep_hs_track u_track (
    .clk(clk), .rst_n(rst_n), .tok_hit(tok_hit), .kind(kind), .hs_now(hs_now),
    .xfer_done(xfer_done), .xfer_ok(xfer_ok), .ctr_q(ctr_q),
    .hs_valid_q(hs_valid), .hs_code_q(hs_code_q), .pid_q(pid_q),
    .pend_q(pend_q), .pkind_q(pkind_q), .done_ok(done_ok)
  );

  ep_hs_regs #(.ISO_ENABLE(ISO_ENABLE)) u_regs (
    .clk(clk), .rst_n(rst_n), .done_ok(done_ok), .done_kind(pkind_q),
    .sw_wr(sw_wr), .sw_cfg(sw_cfg), .sw_ctr(sw_ctr), .cfg_q(cfg_q), .ctr_q(ctr_q)
  );

  ep_hs_bufsel #(.ISO_ENABLE(ISO_ENABLE)) u_bufsel (.cfg(cfg_q), .sel(buf_sel));

  assign hs_code  = hs_code_q;
  assign ctr_flag = ctr_q;
  assign pid_rx   = pid_q;
  assign stat_tx  = cfg_q.tx;
  assign stat_rx  = cfg_q.rx;
  assign cep      = cfg_q.cep;
  assign iso      = cfg_q.iso;
  assign tog_tx   = cfg_q.tog_tx;
  assign tog_rx   = cfg_q.tog_rx;
endmodule

// File: rtl/ep_hs_ctrl_chk.sv
module ep_hs_ctrl_chk #(
  parameter int PID_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tok_valid,
  input logic [PID_W-1:0] tok_pid,
  input logic             xfer_done,
  input logic             xfer_ok,
  input logic             sw_wr,
  input logic             sw_ctr,
  input logic             hs_valid,
  input logic [1:0]       hs_code,
  input logic             ctr_flag,
  input logic [1:0]       pid_rx,
  input logic [1:0]       stat_tx,
  input logic [1:0]       stat_rx,
  input logic             cep,
  input logic             iso,
  input logic             tog_tx,
  input logic             buf_sel,
  input logic             pend_q,
  input logic [1:0]       pkind_q
);
  assert_hs_after_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_valid |-> $past(tok_valid));

  assert_setup_noncontrol_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && $past(tok_pid[PID_W-1:PID_W-2]) == 2'b11 && !$past(cep)) |-> hs_code == 2'b00);

  assert_nak_after_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_ok && pend_q && !iso && !sw_wr && pkind_q == 2'b10)
      |=> (stat_tx == 2'b10 && ctr_flag));

  assert_ctr_clear_by_sw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctr_flag) |-> ($past(sw_wr) && !$past(sw_ctr)));

  assert_pid_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctr_flag) |-> $stable(pid_rx));

  assert_iso_status_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(iso) && !$past(sw_wr)) |-> ($stable(stat_tx) && $stable(stat_rx)));

  assert_iso_no_handshake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && $past(iso)) |-> (hs_code == 2'b00 || hs_code == 2'b01));

  assert_iso_toggle_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && xfer_ok && pend_q && iso && !sw_wr && pkind_q == 2'b10) |=> (tog_tx != $past(tog_tx)));

  assert_bufsel_plain_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !iso |-> !buf_sel);

  assert_iso_one_dir_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (iso && stat_tx != 2'b00) |-> stat_rx == 2'b00);
endmodule

bind ep_hs_ctrl ep_hs_ctrl_chk #(.PID_W(PID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
  .xfer_done(xfer_done), .xfer_ok(xfer_ok), .sw_wr(sw_wr), .sw_ctr(sw_ctr),
  .hs_valid(hs_valid), .hs_code(hs_code), .ctr_flag(ctr_flag), .pid_rx(pid_rx),
  .stat_tx(stat_tx), .stat_rx(stat_rx), .cep(cep), .iso(iso), .tog_tx(tog_tx),
  .buf_sel(buf_sel), .pend_q(pend_q), .pkind_q(pkind_q)
);

// File: tb/ep_hs_ctrl_bench.sv
module ep_hs_ctrl_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       tok_valid = 0, xfer_done = 0, xfer_ok = 0, sw_wr = 0;
  logic [3:0] tok_pid = 0;
  logic [1:0] sw_stat_tx = 0, sw_stat_rx = 0;
  logic       sw_cep = 0, sw_iso = 0, sw_tog_tx = 0, sw_tog_rx = 0, sw_ctr = 0;
  logic       hs_valid, ctr_flag, cep, iso, tog_tx, tog_rx, buf_sel;
  logic [1:0] hs_code, pid_rx, stat_tx, stat_rx;

  ep_hs_ctrl u_ep_hs_ctrl (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
    .xfer_done(xfer_done), .xfer_ok(xfer_ok), .sw_wr(sw_wr),
    .sw_stat_tx(sw_stat_tx), .sw_stat_rx(sw_stat_rx), .sw_cep(sw_cep), .sw_iso(sw_iso),
    .sw_tog_tx(sw_tog_tx), .sw_tog_rx(sw_tog_rx), .sw_ctr(sw_ctr),
    .hs_valid(hs_valid), .hs_code(hs_code), .ctr_flag(ctr_flag), .pid_rx(pid_rx),
    .stat_tx(stat_tx), .stat_rx(stat_rx), .cep(cep), .iso(iso),
    .tog_tx(tog_tx), .tog_rx(tog_rx), .buf_sel(buf_sel)
  );

  localparam logic [3:0] P_OUT = 4'b0001, P_IN = 4'b1001, P_SETUP = 4'b1101;

  int    errors = 0, checks = 0;
  string cur_req = "R1";

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_tx = 0, m_rx = 0, m_cep = 0, m_iso = 0, m_tgt = 0, m_tgr = 0;
  int m_ctr = 0, m_pid = 0, m_pend = 0, m_kind = 0, m_hsv = 0, m_hsc = 0;
  int n_tx, n_rx, n_cep, n_iso, n_tgt, n_tgr, n_ctr, n_pid, n_pend, n_kind;
  int hc, k;
  bit hit, dn;

  function automatic int m_decide(int kk);
    int s;
    s = (kk == 2) ? m_tx : m_rx;
    if (kk == 3) return (m_cep != 0 && (m_rx == 1 || m_rx == 3)) ? 1 : 0;
    if (m_iso != 0) return (s == 3) ? 1 : 0;
    case (s)
      1: return 3;
      2: return 2;
      3: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_cep = 0; m_iso = 0; m_tgt = 0; m_tgr = 0;
      m_ctr = 0; m_pid = 0; m_pend = 0; m_kind = 0; m_hsv = 0; m_hsc = 0;
    end else begin
      hit = tok_valid && tok_pid[1:0] == 2'b01 && tok_pid[3:2] != 2'b01;
      k   = int'(tok_pid[3:2]);
      hc  = hit ? m_decide(k) : 0;
      dn  = xfer_done && xfer_ok && (m_pend != 0);
      n_tx = m_tx; n_rx = m_rx; n_cep = m_cep; n_iso = m_iso; n_tgt = m_tgt; n_tgr = m_tgr;
      n_ctr = m_ctr; n_pid = m_pid; n_pend = m_pend; n_kind = m_kind;
      if (dn) begin
        n_ctr = 1;
        if (m_iso != 0) begin
          if (m_kind == 2) n_tgt = 1 - m_tgt;
          if (m_kind == 0) n_tgr = 1 - m_tgr;
        end else begin
          if (m_kind == 2 || m_kind == 3) n_tx = 2;
          if (m_kind == 0 || m_kind == 3) n_rx = 2;
        end
      end
      if (sw_wr) begin
        n_tx = sw_stat_tx; n_rx = sw_stat_rx; n_cep = sw_cep; n_iso = sw_iso;
        n_tgt = sw_tog_tx; n_tgr = sw_tog_rx;
        if (n_iso != 0 && n_tx != 0) n_rx = 0;
        if (!sw_ctr && !dn) n_ctr = 0;
      end
      if (hit && m_ctr == 0) n_pid = k;
      if (hit) begin n_pend = (hc == 1); n_kind = k; end
      else if (xfer_done) n_pend = 0;
      m_hsv = hit; m_hsc = hc;
      m_tx = n_tx; m_rx = n_rx; m_cep = n_cep; m_iso = n_iso; m_tgt = n_tgt; m_tgr = n_tgr;
      m_ctr = n_ctr; m_pid = n_pid; m_pend = n_pend; m_kind = n_kind;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(cur_req, "hs_valid", hs_valid, m_hsv);
      chk(cur_req, "hs_code", hs_code, m_hsc);
      chk(cur_req, "ctr_flag", ctr_flag, m_ctr);
      chk(cur_req, "pid_rx", pid_rx, m_pid);
      chk(cur_req, "stat_tx", stat_tx, m_tx);
      chk(cur_req, "stat_rx", stat_rx, m_rx);
      chk(cur_req, "tog_tx", tog_tx, m_tgt);
      chk(cur_req, "tog_rx", tog_rx, m_tgr);
      chk(cur_req, "buf_sel", buf_sel, (m_iso != 0) ? ((m_tx != 0) ? m_tgt : m_tgr) : 0);
    end
  end

  task automatic wr(int tx, int rx, int c, int i, int tt, int tr, int keep);
    @(posedge clk); #1;
    sw_wr = 1; sw_stat_tx = tx[1:0]; sw_stat_rx = rx[1:0]; sw_cep = c[0]; sw_iso = i[0];
    sw_tog_tx = tt[0]; sw_tog_rx = tr[0]; sw_ctr = keep[0];
    @(posedge clk); #1;
    sw_wr = 0;
  endtask

  task automatic tok(logic [3:0] p);
    @(posedge clk); #1;
    tok_valid = 1; tok_pid = p;
    @(posedge clk); #1;
    tok_valid = 0;
  endtask

  task automatic done(bit ok);
    @(posedge clk); #1;
    xfer_done = 1; xfer_ok = ok;
    @(posedge clk); #1;
    xfer_done = 0; xfer_ok = 0;
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int map[4];
    map = '{0, 3, 2, 1};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cur_req = "R1";
    chk("R1", "hs_valid", hs_valid, 0);
    chk("R1", "ctr_flag", ctr_flag, 0);
    chk("R1", "stat_tx", stat_tx, 0);
    chk("R1", "stat_rx", stat_rx, 0);
    chk("R1", "pid_rx", pid_rx, 0);
    chk("R1", "buf_sel", buf_sel, 0);

    cur_req = "R2";
    for (int s = 0; s < 4; s++) begin
      wr(s, 0, 0, 0, 0, 0, 1);
      tok(P_IN);
      chk("R2", "hs_valid", hs_valid, 1);
      chk("R2", "hs_code", hs_code, map[s]);
    end

    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      wr(0, s, 0, 0, 0, 0, 1);
      tok(P_OUT);
      chk("R3", "hs_code", hs_code, map[s]);
    end

    cur_req = "R4";
    for (int r = 0; r < 4; r++) begin
      wr(0, r, 1, 0, 0, 0, 1);
      tok(P_SETUP);
      chk("R4", "hs_code setup", hs_code, (r == 1 || r == 3) ? 1 : 0);
    end
    wr(3, 3, 0, 0, 0, 0, 1);
    tok(P_SETUP);
    chk("R4", "hs_code noncontrol", hs_code, 0);
    tok(4'b0101);
    chk("R4", "hs_valid sof", hs_valid, 0);
    tok(4'b1000);
    chk("R4", "hs_valid bad", hs_valid, 0);

    cur_req = "R5";
    wr(3, 0, 0, 0, 0, 0, 0);
    tok(P_IN); done(1);
    chk("R5", "stat_tx after in", stat_tx, 2);
    wr(0, 3, 0, 0, 0, 0, 0);
    tok(P_OUT); done(1);
    chk("R5", "stat_rx after out", stat_rx, 2);
    wr(3, 1, 1, 0, 0, 0, 0);
    tok(P_SETUP);
    chk("R5", "setup accepted", hs_code, 1);
    done(1);
    chk("R5", "stat_tx after setup", stat_tx, 2);
    chk("R5", "stat_rx after setup", stat_rx, 2);
    wr(3, 3, 0, 0, 0, 0, 0);
    tok(P_IN); done(0);
    chk("R5", "stat_tx failed", stat_tx, 3);
    chk("R5", "ctr failed", ctr_flag, 0);

    cur_req = "R6";
    tok(P_IN); done(1);
    chk("R6", "ctr set", ctr_flag, 1);
    wr(2, 0, 0, 0, 0, 0, 1);
    chk("R6", "ctr kept", ctr_flag, 1);
    wr(2, 0, 0, 0, 0, 0, 0);
    chk("R6", "ctr cleared", ctr_flag, 0);

    cur_req = "R7";
    tok(P_OUT);
    chk("R7", "pid out", pid_rx, 0);
    wr(3, 0, 0, 0, 0, 0, 0);
    tok(P_IN);
    chk("R7", "pid in", pid_rx, 2);
    done(1);
    tok(P_SETUP);
    chk("R7", "pid frozen setup", pid_rx, 2);
    tok(P_OUT);
    chk("R7", "pid frozen out", pid_rx, 2);
    wr(3, 0, 1, 0, 0, 0, 0);
    tok(P_SETUP);
    chk("R7", "pid after clear", pid_rx, 3);

    cur_req = "R8";
    wr(3, 0, 0, 1, 0, 0, 0);
    tok(P_IN);
    chk("R8", "iso accept", hs_code, 1);
    done(1);
    chk("R8", "iso stat_tx held", stat_tx, 3);
    wr(2, 0, 0, 1, 0, 0, 0);
    tok(P_IN);
    chk("R8", "iso nak code", hs_code, 0);
    wr(1, 0, 0, 1, 0, 0, 0);
    tok(P_IN);
    chk("R8", "iso stall code", hs_code, 0);

    cur_req = "R9";
    wr(3, 0, 0, 1, 0, 0, 0);
    chk("R10", "buf_sel start", buf_sel, 0);
    for (int i = 0; i < 4; i++) begin
      tok(P_IN); done(1);
      chk("R9", "tog_tx", tog_tx, (i + 1) % 2);
      chk("R10", "buf_sel tx", buf_sel, (i + 1) % 2);
    end
    wr(0, 3, 0, 1, 0, 1, 0);
    chk("R10", "buf_sel rx start", buf_sel, 1);
    for (int i = 0; i < 3; i++) begin
      tok(P_OUT); done(1);
      chk("R9", "tog_rx", tog_rx, i % 2);
      chk("R10", "buf_sel rx", buf_sel, i % 2);
    end
    cur_req = "R10";
    wr(3, 0, 0, 0, 1, 1, 0);
    chk("R10", "buf_sel plain", buf_sel, 0);

    cur_req = "R11";
    wr(3, 3, 0, 1, 0, 0, 0);
    chk("R11", "rx forced off", stat_rx, 0);
    chk("R11", "tx kept", stat_tx, 3);
    wr(0, 3, 0, 1, 0, 0, 0);
    chk("R11", "rx only", stat_rx, 3);

    repeat (4) @(posedge clk);
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule